// File: doc/BRIEF.md
# Timed Transmit Sample Scheduler

This block sits between a transmit DMA stream and a DAC sample port. Software sends packets made of a fixed header and a run of 32-bit I/Q samples. The header holds six synchronisation words and then a 64-bit transmit time, and that time applies to the first sample of the packet. Each accepted packet is held whole in one slot of a circular buffer. It is released to the DAC when the local sample clock, supplied on an input bus, reaches the requested time.

The block runs entirely in the bus clock domain. A one-cycle sample strobe marks each DAC sample period. Exactly one sample, or a zero, leaves on each strobe. When the strobe is held low, output slots are simply not consumed. This lets a late packet be trimmed: samples that are already behind the current time are skipped without stalling the sample stream. A transmit time of zero asks for transmission as soon as possible. Packets with a broken header are discarded and counted. Packets that are wholly in the past are discarded and counted.

Top module: `timed_tx_scheduler`

## Requirements
- R1: A packet is a run of 32-bit words ended by `s_last`. Words 0 to 5 must equal 0xbbbbaaaa, 0xddddcccc, 0xffffeeee, 0xabcddcba, 0xfedccdef and 0xdfcbaefd, in that order. Word 6 holds the low 32 bits of the transmit time and word 7 holds the high 32 bits. Every word from index 8 up to and including the `s_last` word is a sample.
- R2: A packet whose time T is later than `now` is held, and zeros are sent. The packet's first sample is emitted on the first strobe at which `now` equals T.
- R3: The late margin is d = `now` − T. If the buffer head is evaluated on a strobe with 0 < d < packet length, its first d samples are discarded. On that same strobe, sample index d is emitted.
- R4: If d is at least the packet length when the head is evaluated, the whole packet is discarded. On that strobe `late_drop_cnt` increments by one and the output is zero.
- R5: A packet whose time is zero is sent from its first sample, starting on the first strobe after its last word has been accepted.
- R6: A strobe on which no packet sample is due sets `dac_data` to zero.
- R7: Each strobe raises `dac_stb` for exactly one cycle, one cycle later, together with the new `dac_data`. `dac_data` does not change in any other cycle.
- R8: Packets leave in the order they arrived, one sample per strobe and without gaps inside a packet. The next packet is evaluated on the strobe after the previous packet's last sample.
- R9: If a sync word mismatches, or `s_last` arrives before the first sample, the packet is discarded. `sync_err_cnt` then increments by one in the cycle after the `s_last` beat.
- R10: `s_ready` is low while every slot holds a packet. A slot is freed by the strobe that emits its last sample or that discards the packet.
- R11: In reset, `dac_data`, `dac_stb` and both counters are zero, and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_data | input | 32 | Stream word (header or sample) |
| s_valid | input | 1 | Stream word valid |
| s_last | input | 1 | Last word of packet |
| s_ready | output | 1 | Block can accept a word |
| now | input | 64 | Current local sample time |
| strobe | input | 1 | One DAC sample period elapsed |
| dac_data | output | 32 | Sample to the DAC, zero when idle |
| dac_stb | output | 1 | `dac_data` refreshed this cycle |
| sync_err_cnt | output | 16 | Packets rejected for a bad header |
| late_drop_cnt | output | 16 | Packets rejected as fully late |

## Verification
Two events can meet in one cycle: a slot is committed when the last word of a new packet is accepted, and a slot is freed when a strobe emits the head packet's last sample. The bench provokes this by first filling every slot while the strobe is held off. It then streams a further packet while strobes drain the buffer, so that acceptance and release interleave. A behavioural model compares the occupancy-driven `s_ready`, the output sample and both counters on every clock. A lost or double-counted slot therefore shows up either as a stalled or extra accepted word, or as samples emitted out of order.

// File: rtl/tts_pkg.sv
// Shared constants for the timed transmit scheduler.
// Assumes the header is made of 32-bit words: six sync words, then time low, then time high.
package tts_pkg;
    localparam int WORD_W   = 32;
    localparam int TIME_W   = 64;
    localparam int HDR_SYNC = 6;
    localparam int HDR_LEN  = 8;

    // Returns the expected sync word for header position i (0..5).
    function automatic logic [WORD_W-1:0] sync_word(input logic [2:0] i);
        case (i)
            3'd0:    return 32'hbbbbaaaa;
            3'd1:    return 32'hddddcccc;
            3'd2:    return 32'hffffeeee;
            3'd3:    return 32'habcddcba;
            3'd4:    return 32'hfedccdef;
            default: return 32'hdfcbaefd;
        endcase
    endfunction
endpackage

// File: rtl/tts_ingest.sv
// Packet parser and buffer writer.
// Checks the six sync words and collects the 64-bit time, then writes samples into the current slot.
// The slot is committed on s_last only when the header was clean and at least one sample arrived.
// Assumes no packet carries more than DEPTH samples, and that `space` is high only when the slot at wr_ptr is free.
module tts_ingest
    import tts_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int DEPTH = 64,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int LEN_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    input  logic              space,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              ts_we,
    output logic [TIME_W-1:0] ts_val,
    output logic              commit,
    output logic [LEN_W-1:0]  commit_len,
    output logic              sync_err
);
    logic [3:0]        hdr_cnt;
    logic              bad;
    logic [WORD_W-1:0] ts_lo;
    logic [LEN_W-1:0]  samp_cnt;
    logic [SLOT_W-1:0] wr_ptr;
    logic              beat, in_hdr, mism, end_pkt;

    // Decode the current beat against the header position.
    always_comb begin
        beat       = s_valid && space;
        in_hdr     = hdr_cnt < 4'(HDR_LEN);
        mism       = beat && (hdr_cnt < 4'(HDR_SYNC)) && (s_data != sync_word(hdr_cnt[2:0]));
        end_pkt    = beat && s_last;
        wr_en      = beat && !in_hdr;
        wr_slot    = wr_ptr;
        wr_idx     = samp_cnt[IDX_W-1:0];
        ts_we      = beat && (hdr_cnt == 4'(HDR_LEN - 1));
        ts_val     = {s_data, ts_lo};
        commit     = end_pkt && !in_hdr && !bad;
        commit_len = samp_cnt + LEN_W'(1);
        sync_err   = end_pkt && (in_hdr || bad);
    end

    // Advance the header/sample position and the slot pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_cnt  <= '0;
            bad      <= 1'b0;
            ts_lo    <= '0;
            samp_cnt <= '0;
            wr_ptr   <= '0;
        end else if (end_pkt) begin
            hdr_cnt  <= '0;
            bad      <= 1'b0;
            samp_cnt <= '0;
            if (commit)
                wr_ptr <= (wr_ptr == SLOT_W'(SLOTS - 1)) ? '0 : wr_ptr + SLOT_W'(1);
        end else if (beat) begin
            if (in_hdr)
                hdr_cnt <= hdr_cnt + 4'd1;
            else
                samp_cnt <= samp_cnt + LEN_W'(1);
            if (mism)
                bad <= 1'b1;
            if (hdr_cnt == 4'(HDR_LEN - 2))
                ts_lo <= s_data;
        end
    end
endmodule

// File: rtl/tts_slot_ram.sv
// Circular buffer storage: one slot per packet, plus the time and length of each slot.
// Writes are registered and reads are asynchronous. The contents need no reset, because
// a slot is read only after the ingest side has committed it.
module tts_slot_ram
    import tts_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int DEPTH = 64,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int LEN_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ts_we,
    input  logic [TIME_W-1:0] ts_val,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_val,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic [TIME_W-1:0] head_ts,
    output logic [LEN_W-1:0]  head_len
);
    logic [WORD_W-1:0] mem     [SLOTS][DEPTH];
    logic [TIME_W-1:0] ts_mem  [SLOTS];
    logic [LEN_W-1:0]  len_mem [SLOTS];

    // Store samples and per-slot metadata.
    always_ff @(posedge clk) begin
        if (wr_en)  mem[wr_slot][wr_idx] <= wr_data;
        if (ts_we)  ts_mem[wr_slot]      <= ts_val;
        if (len_we) len_mem[wr_slot]     <= len_val;
    end

    // Present the addressed sample and the head slot's metadata.
    always_comb begin
        rd_data  = mem[rd_slot][rd_idx];
        head_ts  = ts_mem[rd_slot];
        head_len = len_mem[rd_slot];
    end
endmodule

// File: rtl/tts_release.sv
// Release scheduler. On each strobe it either continues the active packet,
// starts the head packet (immediate, on time, or trimmed when late),
// discards a fully late head, or emits zero.
// Assumes head_avail is high only when the slot at rd_slot is committed.
module tts_release
    import tts_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int DEPTH = 64,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int LEN_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [TIME_W-1:0] now,
    input  logic              head_avail,
    input  logic [TIME_W-1:0] head_ts,
    input  logic [LEN_W-1:0]  head_len,
    input  logic [WORD_W-1:0] rd_data,
    output logic [SLOT_W-1:0] rd_slot,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              free,
    output logic              late_drop,
    output logic [WORD_W-1:0] dac_data,
    output logic              dac_stb
);
    logic              active;
    logic [IDX_W-1:0]  pos;
    logic [SLOT_W-1:0] rd_ptr;
    logic [TIME_W-1:0] delta;
    logic              due, behind, gone, send, last;
    logic [IDX_W-1:0]  idx;

    // Choose this strobe's action and the sample index to read.
    always_comb begin
        delta  = now - head_ts;
        due    = (head_ts == '0) || (head_ts == now);
        behind = (head_ts != '0) && (head_ts < now);
        gone   = behind && (delta >= TIME_W'(head_len));
        send   = 1'b0;
        late_drop = 1'b0;
        idx    = pos;
        if (strobe) begin
            if (active) begin
                send = 1'b1;
            end else if (head_avail) begin
                if (due) begin
                    send = 1'b1;
                    idx  = '0;
                end else if (gone) begin
                    late_drop = 1'b1;
                end else if (behind) begin
                    send = 1'b1;
                    idx  = IDX_W'(delta);
                end
            end
        end
        last    = (LEN_W'(idx) == head_len - LEN_W'(1));
        free    = (send && last) || late_drop;
        rd_slot = rd_ptr;
        rd_idx  = idx;
    end

    // Register the output sample and advance the packet position and the head pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            pos      <= '0;
            rd_ptr   <= '0;
            dac_data <= '0;
            dac_stb  <= 1'b0;
        end else begin
            dac_stb <= strobe;
            if (strobe)
                dac_data <= send ? rd_data : '0;
            if (free) begin
                active <= 1'b0;
                rd_ptr <= (rd_ptr == SLOT_W'(SLOTS - 1)) ? '0 : rd_ptr + SLOT_W'(1);
            end else if (send) begin
                active <= 1'b1;
                pos    <= idx + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/timed_tx_scheduler.sv
// Top level of the timed transmit scheduler.
// Ties together the parser, the slot storage and the release scheduler.
// Keeps the slot occupancy, which drives back-pressure, and the two drop counters.
// Assumes SLOTS >= 2 and DEPTH is a power of two.
module timed_tx_scheduler
    import tts_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int DEPTH = 64,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    input  logic [TIME_W-1:0] now,
    input  logic              strobe,
    output logic [WORD_W-1:0] dac_data,
    output logic              dac_stb,
    output logic [CNT_W-1:0]  sync_err_cnt,
    output logic [CNT_W-1:0]  late_drop_cnt
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int LEN_W  = IDX_W + 1;
    localparam int OCC_W  = $clog2(SLOTS + 1);

    logic [OCC_W-1:0]  occ;
    logic              wr_en, ts_we, commit, sync_err, free, late_drop;
    logic [SLOT_W-1:0] wr_slot, rd_slot;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [TIME_W-1:0] ts_val, head_ts;
    logic [LEN_W-1:0]  commit_len, head_len;
    logic [WORD_W-1:0] rd_data;

    assign s_ready = (occ != OCC_W'(SLOTS));

    tts_ingest #(.SLOTS(SLOTS), .DEPTH(DEPTH)) u_ingest (
        .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
        .space(s_ready), .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx),
        .ts_we(ts_we), .ts_val(ts_val), .commit(commit), .commit_len(commit_len),
        .sync_err(sync_err)
    );

    tts_slot_ram #(.SLOTS(SLOTS), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx), .wr_data(s_data),
        .ts_we(ts_we), .ts_val(ts_val), .len_we(commit), .len_val(commit_len),
        .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_data(rd_data),
        .head_ts(head_ts), .head_len(head_len)
    );

    tts_release #(.SLOTS(SLOTS), .DEPTH(DEPTH)) u_release (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .now(now),
        .head_avail(occ != '0), .head_ts(head_ts), .head_len(head_len),
        .rd_data(rd_data), .rd_slot(rd_slot), .rd_idx(rd_idx), .free(free),
        .late_drop(late_drop), .dac_data(dac_data), .dac_stb(dac_stb)
    );

    // Track committed slots and count discarded packets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ           <= '0;
            sync_err_cnt  <= '0;
            late_drop_cnt <= '0;
        end else begin
            occ <= occ + OCC_W'(commit) - OCC_W'(free);
            if (sync_err)  sync_err_cnt  <= sync_err_cnt + CNT_W'(1);
            if (late_drop) late_drop_cnt <= late_drop_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/tts_chk.sv
// Port-level protocol checks for timed_tx_scheduler, attached with bind.
module tts_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_valid,
    input logic             s_ready,
    input logic             s_last,
    input logic             strobe,
    input logic [31:0]      dac_data,
    input logic             dac_stb,
    input logic [CNT_W-1:0] sync_err_cnt,
    input logic [CNT_W-1:0] late_drop_cnt
);
    // R7
    stb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> dac_stb);
    // R7
    stb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> (!dac_stb && $stable(dac_data)));
    // R9
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_valid && s_ready && s_last) |=> $stable(sync_err_cnt));
    // R9
    sync_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_last) |=>
        (sync_err_cnt == $past(sync_err_cnt) || sync_err_cnt == $past(sync_err_cnt) + 1'b1));
    // R4
    late_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(late_drop_cnt));
    // R4
    late_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (late_drop_cnt == $past(late_drop_cnt) || dac_data == '0));
    // R11
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (dac_data == '0 && !dac_stb && s_ready &&
                    sync_err_cnt == '0 && late_drop_cnt == '0));
endmodule

bind timed_tx_scheduler tts_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last),
    .strobe(strobe), .dac_data(dac_data), .dac_stb(dac_stb),
    .sync_err_cnt(sync_err_cnt), .late_drop_cnt(late_drop_cnt)
);

// File: tb/sim_timed_tx_scheduler.sv
`timescale 1ns/1ps
// Bench: behavioural queue model of the scheduler, compared on every clock.
module sim_timed_tx_scheduler;
    localparam int SLOTS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] s_data = '0;
    logic        s_valid = 1'b0, s_last = 1'b0, s_ready;
    logic [63:0] now = 64'd100;
    logic        strobe = 1'b0, dac_stb;
    logic [31:0] dac_data;
    logic [15:0] sync_err_cnt, late_drop_cnt;
    bit          stb_en = 1'b0;
    bit          done = 1'b0;
    int          checks = 0, errors = 0;

    always #2 clk = ~clk;

    timed_tx_scheduler u0 (
        .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
        .s_ready(s_ready), .now(now), .strobe(strobe), .dac_data(dac_data),
        .dac_stb(dac_stb), .sync_err_cnt(sync_err_cnt), .late_drop_cnt(late_drop_cnt)
    );

    function automatic logic [31:0] syncw(input int i);
        case (i)
            0: return 32'hbbbbaaaa;
            1: return 32'hddddcccc;
            2: return 32'hffffeeee;
            3: return 32'habcddcba;
            4: return 32'hfedccdef;
            default: return 32'hdfcbaefd;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    longint unsigned q_ts[$];
    int              q_len[$];
    logic [31:0]     q_s[$];
    logic [31:0]     tmp[$];
    bit              m_act, m_ready = 1'b1, mbad;
    int              m_rem, widx;
    logic [31:0]     e_data, tslo, tshi;
    bit              e_stb;
    int              e_sync, e_late;
    bit              seen_imm, seen_due, seen_skip;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_ts.delete(); q_len.delete(); q_s.delete(); tmp.delete();
            m_act = 0; m_ready = 1; mbad = 0; m_rem = 0; widx = 0;
            e_data = 0; e_stb = 0; e_sync = 0; e_late = 0;
        end else begin
            bit acc;
            acc = s_valid && m_ready;
            e_stb = strobe;
            if (strobe) begin
                e_data = 0;
                if (m_act) begin
                    e_data = q_s.pop_front();
                    m_rem--;
                    if (m_rem == 0) begin
                        m_act = 0; void'(q_ts.pop_front()); void'(q_len.pop_front());
                    end
                end else if (q_len.size() > 0) begin
                    longint unsigned t, tn;
                    int n, skip;
                    bit go;
                    t = q_ts[0]; n = q_len[0]; tn = now; go = 0; skip = 0;
                    if (t == 0 || t == tn) begin
                        go = 1;
                        if (t == 0) seen_imm = 1; else seen_due = 1;
                    end else if (t < tn) begin
                        if ((tn - t) >= 64'(n)) begin
                            repeat (n) void'(q_s.pop_front());
                            void'(q_ts.pop_front()); void'(q_len.pop_front());
                            e_late++;
                        end else begin
                            go = 1; skip = int'(tn - t); seen_skip = 1;
                        end
                    end
                    if (go) begin
                        repeat (skip) void'(q_s.pop_front());
                        e_data = q_s.pop_front();
                        m_rem = n - skip - 1;
                        if (m_rem == 0) begin
                            void'(q_ts.pop_front()); void'(q_len.pop_front());
                        end else m_act = 1;
                    end
                end
            end
            if (acc) begin
                bit hdr;
                hdr = (widx < 8);
                if (hdr) begin
                    if (widx < 6 && s_data != syncw(widx)) mbad = 1;
                    if (widx == 6) tslo = s_data;
                    if (widx == 7) tshi = s_data;
                    widx++;
                end else tmp.push_back(s_data);
                if (s_last) begin
                    if (hdr || mbad) e_sync++;
                    else begin
                        q_ts.push_back({tshi, tslo});
                        q_len.push_back(tmp.size());
                        foreach (tmp[k]) q_s.push_back(tmp[k]);
                    end
                    tmp.delete(); widx = 0; mbad = 0;
                end
            end
            m_ready = (q_len.size() < SLOTS);
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(dac_data == e_data, "R1 R2 R3 R5 R6 R8 dac_data", 64'(dac_data), 64'(e_data));
            chk(dac_stb == e_stb, "R7 dac_stb", 64'(dac_stb), 64'(e_stb));
            chk(s_ready == m_ready, "R10 s_ready", 64'(s_ready), 64'(m_ready));
            chk(sync_err_cnt == 16'(e_sync), "R9 sync_err_cnt", 64'(sync_err_cnt), 64'(e_sync));
            chk(late_drop_cnt == 16'(e_late), "R4 late_drop_cnt", 64'(late_drop_cnt), 64'(e_late));
        end
    end

    // Strobe every other cycle when enabled; time advances after each strobe.
    initial begin
        forever begin
            @(negedge clk);
            if (strobe) now = now + 64'd1;
            strobe = stb_en && !strobe;
        end
    end

    task automatic send_pkt(input longint unsigned ts, input int n, input int base,
                            input int bad_w, input int cut);
        logic [31:0] w[$];
        bit ok;
        for (int i = 0; i < 6; i++) w.push_back(i == bad_w ? syncw(i) ^ 32'h1 : syncw(i));
        w.push_back(ts[31:0]);
        w.push_back(ts[63:32]);
        for (int i = 0; i < n; i++) w.push_back(32'h1000_0000 + 32'(base + i));
        if (cut > 0) while (w.size() > cut) void'(w.pop_back());
        for (int i = 0; i < w.size(); i++) begin
            s_valid = 1; s_data = w[i]; s_last = (i == w.size() - 1);
            ok = s_ready;
            @(negedge clk);
            while (!ok) begin
                ok = s_ready;
                @(negedge clk);
            end
        end
        s_valid = 0; s_last = 0; s_data = '0;
    endtask

    task automatic drain();
        while (q_len.size() != 0 || m_act) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(dac_data == 0, "R11 dac_data", 64'(dac_data), 0);
        chk(dac_stb == 0, "R11 dac_stb", 64'(dac_stb), 0);
        chk(s_ready == 1, "R11 s_ready", 64'(s_ready), 1);
        chk(sync_err_cnt == 0 && late_drop_cnt == 0, "R11 counters",
            64'(sync_err_cnt) + 64'(late_drop_cnt), 0);
        rst_n = 1;
        stb_en = 1;
        repeat (6) @(negedge clk);
        // R5: immediate packet
        send_pkt(0, 5, 16, -1, 0);
        drain();
        chk(seen_imm, "R5 immediate start reached", 64'(seen_imm), 1);
        // R2: early packet
        send_pkt(now + 64'd40, 4, 48, -1, 0);
        drain();
        chk(seen_due, "R2 on-time start reached", 64'(seen_due), 1);
        // R3: partly late packet
        send_pkt(now - 64'd2, 40, 96, -1, 0);
        drain();
        chk(seen_skip, "R3 trimmed start reached", 64'(seen_skip), 1);
        chk(late_drop_cnt == 0, "R3 no whole drop", 64'(late_drop_cnt), 0);
        // R4: fully late packet
        send_pkt(64'd1, 4, 160, -1, 0);
        drain();
        chk(late_drop_cnt == 1, "R4 late count", 64'(late_drop_cnt), 1);
        // R9: bad sync word, then header-only packet
        send_pkt(0, 3, 200, 2, 0);
        send_pkt(0, 3, 210, -1, 8);
        drain();
        chk(sync_err_cnt == 2, "R9 sync count", 64'(sync_err_cnt), 2);
        // R10: fill every slot with the strobe held off
        stb_en = 0;
        repeat (4) @(negedge clk);
        for (int p = 0; p < SLOTS; p++) send_pkt(0, 3, 300 + 8 * p, -1, 0);
        chk(s_ready == 0, "R10 full back-pressure", 64'(s_ready), 0);
        fork
            send_pkt(0, 6, 400, -1, 0);
            begin repeat (6) @(negedge clk); stb_en = 1; end
        join
        drain();
        // R8/R6: back-to-back mixed packets
        send_pkt(0, 2, 500, -1, 0);
        send_pkt(now + 64'd30, 3, 520, -1, 0);
        send_pkt(0, 4, 540, -1, 0);
        drain();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule